// File: doc/BRIEF.md
# Pointer Increment Representability Checker

This block is a purely combinational helper for a compressed-capability datapath. When software moves a capability's address by a signed 64-bit step, the block produces the moved address. It also produces a flag. The flag says whether the base and top that the capability encodes can still be recovered from the moved address without ambiguity. The capability stores a 6-bit exponent E and a 20-bit bottom field, and the block receives both.

The decision looks at only a few parts of the operands. It reads the middle 20-bit slice of the address and of the step, both taken at bit E. It reads the sign of the step and tests whether the step's bits above that slice are all copies of the sign. It then compares the slices against a limit placed 2^12 units below the bottom field. The comparison is deliberately conservative: it gives up one unit when moving upward, in case a carry arrives from the low bits, and it refuses any downward move when the address already sits on the limit.

The block does not test whether the address lies within the dereferenceable bounds, does not clear tags and raises no exception. The surrounding datapath acts on the flag.

Top module: `ptr_step_repr`

## Requirements
- R1: `next_addr` always equals `cur_addr + step` modulo 2^64, whatever value `fits` takes.
- R2: The limit used by the slice tests is `bot_field - 4096` taken modulo 2^20.
- R3: The step is in range when every bit of `step` from position E+20 up to bit 63 equals bit 63. When E+20 is 63 or more, the step counts as in range.
- R4: For a step whose bit 63 is 0, the in-limits condition holds when the unsigned 20-bit slice `step[E+19:E]` is less than (limit − `cur_addr[E+19:E]` − 1), with the difference taken modulo 2^20.
- R5: For a step whose bit 63 is 1, the in-limits condition holds when the step slice is greater than or equal to (limit − address slice) modulo 2^20, and in addition the limit differs from the address slice.
- R6: When `exp_val` is 44 or greater, `fits` is 1 regardless of the other inputs.
- R7: When `exp_val` is below 44, `fits` is 1 exactly when the step is in range (R3) and in limits (R4/R5).
- R8: A zero step is treated as an upward move, so an address slice equal to limit − 1 gives `fits` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_addr | input | 64 | Address held in the capability before the move |
| step | input | 64 | Signed two's-complement increment |
| exp_val | input | 6 | Exponent E of the compressed bounds |
| bot_field | input | 20 | Encoded bottom field of the bounds |
| next_addr | output | 64 | Moved address |
| fits | output | 1 | 1 when the moved capability is still representable |

## Verification
The bench builds the block with its default widths: a 64-bit address, a 20-bit middle slice, a 6-bit exponent, a limit offset of 2^12 and an override threshold of 44. With these widths the directed cases cover the following:
- the wrap of the limit below zero when the bottom field is under 4096;
- the single-unit margin at limit − 1 for upward moves;
- the stuck-at-limit case for downward moves;
- exponent 42, where both bit 62 and bit 63 of the step are tested for the in-range check;
- exponent 43, where only bit 63 is tested;
- the exponent 44 override.

Random vectors then mix exponents across the full 0–63 span with both step signs.

// File: rtl/ptr_step_pkg.sv
// Package: shared widths and constants of the pointer-step checker.
// Assumes a two's-complement step whose sign is the top address bit.
package ptr_step_pkg;
    localparam int ADDR_W   = 64;  // address and step width
    localparam int MID_W    = 20;  // width of the middle slice
    localparam int EXP_W    = 6;   // exponent field width
    localparam int GAP_LOG  = 12;  // limit sits 2^GAP_LOG below the bottom field
    localparam int WIDE_EXP = 44;  // exponent at which every move is accepted
endpackage

// File: rtl/ptr_step_slice.sv
// Module: extracts the MID_W-bit slice of a word starting at bit position sh.
// Assumes sh may reach past the word's top; missing bits read as zero.
module ptr_step_slice #(
    parameter int WORD_W = 64,
    parameter int MID_W  = 20,
    parameter int SH_W   = 6
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [SH_W-1:0]   sh,
    output logic [MID_W-1:0]  mid_out
);
    logic [WORD_W-1:0] shifted;

    // Purpose: right-shift by the exponent and keep the low MID_W bits.
    always_comb begin
        shifted = word_in >> sh;
        mid_out = shifted[MID_W-1:0];
    end
endmodule

// File: rtl/ptr_step_range.sv
// Module: decides whether the step's bits above the middle slice are all
// copies of its sign bit. Assumes position exp+MID_W may lie beyond the top bit.
module ptr_step_range #(
    parameter int WORD_W = 64,
    parameter int MID_W  = 20,
    parameter int EXP_W  = 6
) (
    input  logic [WORD_W-1:0] step_in,
    input  logic [EXP_W-1:0]  exp_in,
    output logic              in_range
);
    localparam int LIM_W = EXP_W + 2;

    logic [LIM_W-1:0]  first_hi;
    logic [WORD_W-1:0] bad_bit;

    // Purpose: lowest bit position that belongs to the upper part of the step.
    always_comb first_hi = LIM_W'(exp_in) + LIM_W'(MID_W);

    // Purpose: flag every upper bit that disagrees with the sign bit.
    for (genvar k = 0; k < WORD_W; k++) begin : g_bit
        always_comb bad_bit[k] = (LIM_W'(k) >= first_hi) &&
                                 (step_in[k] != step_in[WORD_W-1]);
    end

    // Purpose: the step is in range when no upper bit disagrees.
    always_comb in_range = (bad_bit == '0);

    // Purpose: guard the empty-upper-part corner.
    always_comb begin
        // R3
        upper_empty_chk: assert (first_hi < LIM_W'(WORD_W) || in_range)
            else $error("upper part empty but step marked out of range");
    end
endmodule

// File: rtl/ptr_step_limits.sv
// Module: checks the middle slices against the representable limit, with the
// conservative margins for each direction. Assumes all slice arithmetic wraps.
module ptr_step_limits #(
    parameter int MID_W   = 20,
    parameter int GAP_LOG = 12
) (
    input  logic [MID_W-1:0] addr_mid,
    input  logic [MID_W-1:0] step_mid,
    input  logic [MID_W-1:0] bot_in,
    input  logic             step_neg,
    output logic             in_limits
);
    logic [MID_W-1:0] limit;
    logic [MID_W-1:0] room;
    logic             up_ok;
    logic             down_ok;

    // Purpose: place the limit below the bottom field, wrapping modulo 2^MID_W.
    always_comb limit = bot_in - MID_W'(1 << GAP_LOG);

    // Purpose: distance from the address slice up to the limit.
    always_comb room = limit - addr_mid;

    // Purpose: upward move keeps one unit of margin for a low-order carry.
    always_comb up_ok = step_mid < (room - MID_W'(1));

    // Purpose: downward move must not start on the limit itself.
    always_comb down_ok = (step_mid >= room) && (room != '0);

    // Purpose: choose the direction by the step's sign.
    always_comb in_limits = step_neg ? down_ok : up_ok;

    // Purpose: guard the direction-specific corners.
    always_comb begin
        // R5
        on_limit_chk: assert (!(step_neg && addr_mid == limit) || !in_limits)
            else $error("downward move accepted from the limit");
        // R4
        no_room_chk: assert (!(!step_neg && addr_mid == limit - MID_W'(1)) || !in_limits)
            else $error("upward move accepted with no room");
    end
endmodule

// File: rtl/ptr_step_repr.sv
// Module: top of the pointer-step checker. Forms the moved address and the
// representable flag. Purely combinational; assumes the incoming capability
// was representable before the move.
module ptr_step_repr
    import ptr_step_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int M_W   = MID_W,
    parameter int E_W   = EXP_W,
    parameter int G_LOG = GAP_LOG,
    parameter int E_BIG = WIDE_EXP
) (
    input  logic [A_W-1:0] cur_addr,
    input  logic [A_W-1:0] step,
    input  logic [E_W-1:0] exp_val,
    input  logic [M_W-1:0] bot_field,
    output logic [A_W-1:0] next_addr,
    output logic           fits
);
    logic [M_W-1:0] a_mid;
    logic [M_W-1:0] s_mid;
    logic           rng_ok;
    logic           lim_ok;
    logic           exp_wide;

    ptr_step_slice #(.WORD_W(A_W), .MID_W(M_W), .SH_W(E_W)) u_amid (
        .word_in(cur_addr), .sh(exp_val), .mid_out(a_mid)
    );

    ptr_step_slice #(.WORD_W(A_W), .MID_W(M_W), .SH_W(E_W)) u_smid (
        .word_in(step), .sh(exp_val), .mid_out(s_mid)
    );

    ptr_step_range #(.WORD_W(A_W), .MID_W(M_W), .EXP_W(E_W)) u_rng (
        .step_in(step), .exp_in(exp_val), .in_range(rng_ok)
    );

    ptr_step_limits #(.MID_W(M_W), .GAP_LOG(G_LOG)) u_lim (
        .addr_mid(a_mid), .step_mid(s_mid), .bot_in(bot_field),
        .step_neg(step[A_W-1]), .in_limits(lim_ok)
    );

    // Purpose: full-width move of the address, independent of the flag.
    always_comb next_addr = cur_addr + step;

    // Purpose: exponents at or above the threshold accept any move.
    always_comb exp_wide = (32'(exp_val) >= E_BIG);

    // Purpose: combine the fast tests into the representable flag.
    always_comb fits = (rng_ok && lim_ok) || exp_wide;

    // Purpose: guard the flag against its sub-block results.
    always_comb begin
        // R6
        wide_exp_chk: assert (!exp_wide || fits)
            else $error("wide exponent but move rejected");
        // R7
        narrow_need_range_chk: assert (exp_wide || !fits || (rng_ok && lim_ok))
            else $error("move accepted without both fast tests");
        // R1
        moved_addr_chk: assert (next_addr - step == cur_addr)
            else $error("moved address does not match the step");
    end
endmodule

// File: tb/ptr_step_repr_test.sv
// Bench: behavioural reference for the pointer-step checker, compared every clock.
module ptr_step_repr_test;
    logic        clk = 1'b0;
    logic [63:0] cur_addr = '0;
    logic [63:0] step = '0;
    logic [5:0]  exp_val = '0;
    logic [19:0] bot_field = 20'h01000;
    logic [63:0] next_addr;
    logic        fits;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    ptr_step_repr uut (
        .cur_addr(cur_addr), .step(step), .exp_val(exp_val),
        .bot_field(bot_field), .next_addr(next_addr), .fits(fits)
    );

    // Reference flag from the requirements, in integer arithmetic.
    function automatic bit ref_fits(longint unsigned a, longint unsigned s,
                                    int e, int b);
        longint signed hi;
        longint unsigned msk = 64'hFFFFF;
        longint unsigned lim, am, sm, room;
        bit inr, inl;
        if (e >= 44) return 1;                             // R6
        hi  = $signed(s) >>> (e + 20);
        inr = (hi == 0) || (hi == -1);                     // R3
        lim = (longint'(b) - 4096) & msk;                  // R2
        am  = (a >> e) & msk;
        sm  = (s >> e) & msk;
        room = (lim - am) & msk;
        if (s[63] == 1'b0) inl = sm < ((room - 1) & msk);  // R4, R8
        else inl = (sm >= room) && (lim != am);            // R5
        return inr && inl;                                 // R7
    endfunction

    task automatic apply(input logic [63:0] a, input logic [63:0] s,
                         input int e, input int b, input string tag);
        bit exp_f;
        logic [63:0] exp_a;
        @(posedge clk);
        cur_addr = a; step = s; exp_val = 6'(e); bot_field = 20'(b);
        @(negedge clk);
        exp_f = ref_fits(a, s, e, b);
        exp_a = a + s;
        checks++;
        if (fits !== exp_f) begin
            errors++;
            $display("FAIL %s fits actual %0b expected %0b (a=%h s=%h e=%0d b=%h)",
                     tag, fits, exp_f, a, s, e, b);
        end
        checks++;
        if (next_addr !== exp_a) begin
            errors++;
            $display("FAIL R1 next_addr actual %h expected %h", next_addr, exp_a);
        end
    endtask

    initial begin
        // Quiet state: zero step from address 0, limit 0.
        apply(64'h0, 64'h0, 0, 'h01000, "R8");
        // R2: bottom below 4096 wraps the limit to 0xFF000.
        apply(64'h000FEFFE, 64'h1, 0, 'h00000, "R2");
        apply(64'h000FEFFF, 64'h0, 0, 'h00000, "R2");
        // R4 / R8: upward margin at the limit minus one and minus two.
        apply(64'h000FFFFE, 64'h0, 0, 'h01000, "R4");
        apply(64'h000FFFFF, 64'h0, 0, 'h01000, "R8");
        apply(64'h00000000, 64'h000FFFFE, 0, 'h01000, "R4");
        apply(64'h00000000, 64'h000FFFFD, 0, 'h01000, "R4");
        // R5: downward from the limit, and one above it.
        apply(64'h00000000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 'h01000, "R5");
        apply(64'h00000001, 64'hFFFF_FFFF_FFFF_FFFF, 0, 'h01000, "R5");
        // R3: bit 20 set with exponent 0 is out of range.
        apply(64'h00000000, 64'h00100000, 0, 'h01000, "R3");
        // R3: exponent 42 sees bits 62 and 63; exponent 43 only bit 63.
        apply(64'h0, 64'h4000_0000_0000_0000, 42, 'h01000, "R3");
        apply(64'h0, 64'h8000_0000_0000_0000, 43, 'h01000, "R3");
        // R6: exponent 44 and 63 accept anything.
        apply(64'h0, 64'h4000_0000_0000_0000, 44, 'h00000, "R6");
        apply(64'h000FFFFF, 64'h0, 63, 'h01000, "R6");
        // R7: random mix across exponents and signs.
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] ra, rs;
            int re;
            ra = {$urandom, $urandom};
            rs = {$urandom, $urandom};
            re = $urandom_range(0, 63);
            if (i % 3 == 0) rs = 64'($signed(32'($urandom)) >>> $urandom_range(0, 31)) <<< (re % 24);
            apply(ra, rs, re, int'($urandom & 32'hFFFFF), "R7");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule